// File: doc/BRIEF.md
# Far-end alarm codeword transmitter

This block produces the outgoing serial far-end alarm and control bit stream for a DS3/E3 framer. Software loads two 6-bit alarm codes, A and B, through simple write strobes and picks one of four operating modes. The block wraps the chosen code in a 16-bit codeword and shifts it out one bit for each pulse of the framer's bit-slot enable. Idle time is filled with ones.

In single mode, code A's codeword goes out ten times and the line then returns to ones. In dual mode, ten A codewords are followed by ten B codewords. In continuous mode, code A's codeword repeats until a new mode is written. A one-cycle done pulse marks the end of a finite sequence. A mode change never cuts a codeword short: it takes effect at the next codeword boundary.

Top module: `feac_tx`

## Requirements
- R1: After synchronous reset, `tx_bit` is 1 and `seq_done` is 0.
- R2: A codeword is sent in this order: a 0, code register bits 0 through 5 (bit 0 first), a 0, then eight 1s.
- R3: In idle mode (`wr_mode_sel` = 0), and whenever no sequence is running, every enabled bit slot carries a 1.
- R4: Single mode (`wr_mode_sel` = 1) sends code A's codeword ten times in a row, then sends 1s.
- R5: Dual mode (`wr_mode_sel` = 2) sends code A's codeword ten times, then code B's codeword ten times, then sends 1s.
- R6: Continuous mode (`wr_mode_sel` = 3) repeats code A's codeword with no end and never raises `seq_done`.
- R7: `tx_bit` changes only on a clock edge where `bit_en` is high. A cycle with `bit_en` low neither changes the output nor advances the sequence.
- R8: A mode write takes effect at the next codeword boundary. A codeword in flight completes first. When nothing is in flight, the new sequence starts at the next enabled slot.
- R9: A code register write does not alter the codeword in flight. It is used from the next codeword onward.
- R10: `seq_done` is high for exactly one cycle: the cycle in which the final bit of a single or dual sequence is on `tx_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_code_a | input | 1 | Write strobe that loads `wr_code` into code A |
| wr_code_b | input | 1 | Write strobe that loads `wr_code` into code B |
| wr_mode | input | 1 | Write strobe that loads `wr_mode_sel` and requests a new sequence |
| wr_code | input | 6 | Code value; bit 0 is transmitted first |
| wr_mode_sel | input | 2 | 0 idle, 1 single, 2 dual, 3 continuous |
| bit_en | input | 1 | Bit-slot enable from the framer |
| tx_bit | output | 1 | Serial output bit |
| seq_done | output | 1 | One-cycle pulse at the end of a single or dual sequence |

## Verification
On every cycle, the assertions check five things: the output holds while the enable is low, every loaded codeword starts with a 0, the final bit of every codeword is a 1, the repeat count stays in range, and the done pulse lasts one cycle, only with the sequencer off and never in continuous mode. A mode write always leaves a pending request behind. The exact order of bits, the count of ten codewords per code, the switch from A to B, and the deferral of mode and code writes to a codeword boundary can only be shown by the bench's scenarios. The bench sweeps all 64 codes through single mode and all 64 B codes through dual mode.

// File: rtl/feac_tx_pkg.sv
// Shared types for the far-end alarm codeword transmitter.
package feac_tx_pkg;

    // Operating mode as written through wr_mode_sel.
    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_SINGLE = 2'd1,
        MODE_DUAL   = 2'd2,
        MODE_CONT   = 2'd3
    } feac_mode_e;

    // Which code the sequencer is currently sending.
    typedef enum logic [1:0] {
        PH_OFF = 2'd0,
        PH_A   = 2'd1,
        PH_B   = 2'd2
    } feac_phase_e;

endpackage

// File: rtl/feac_tx_regs.sv
// Code and mode registers.
// Holds codes A and B and the mode. Raises a pending-start flag on every
// mode write; the flag stays up until the sequencer consumes it at a
// codeword boundary.
// Assumes the write strobes are single-cycle and synchronous to clk.
module feac_tx_regs
    import feac_tx_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_code_a,
    input  logic              wr_code_b,
    input  logic              wr_mode,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [1:0]        wr_mode_sel,
    input  logic              consume,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output feac_mode_e        mode,
    output logic              pend
);

    // Register writes and the pending-start flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_a <= '0;
            code_b <= '0;
            mode   <= MODE_IDLE;
            pend   <= 1'b0;
        end else begin
            if (wr_code_a) code_a <= wr_code;
            if (wr_code_b) code_b <= wr_code;
            if (wr_mode)   mode   <= feac_mode_e'(wr_mode_sel);
            pend <= wr_mode | (pend & ~consume);
        end
    end

    // R8: a mode write always leaves a pending start request.
    a_r8_pend_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode |=> pend);

endmodule

// File: rtl/feac_tx_shift.sv
// Codeword shifter.
// Builds the codeword from a code: 0, code bits 0 upward, 0, then the
// trailing ones. Sends one bit per enabled slot. When the shifter is at a
// boundary and no load is requested, it sends 1s.
// Assumes load is asserted only together with bit_en at a boundary.
module feac_tx_shift #(
    parameter int CODE_W  = 6,
    parameter int TRAIL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              load,
    input  logic [CODE_W-1:0] code,
    output logic              tx_bit,
    output logic              at_boundary,
    output logic              at_last
);

    localparam int WORD_W = CODE_W + 2 + TRAIL_W;
    localparam int POS_W  = $clog2(WORD_W);

    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] cw;
    logic [POS_W-1:0]  pos;

    // Codeword in transmit order, with bit 0 sent first.
    assign cw          = {{TRAIL_W{1'b1}}, 1'b0, code, 1'b0};
    assign at_boundary = (pos == '0);
    assign at_last     = (pos == POS_W'(WORD_W - 1));

    // Bit position, held codeword and output bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word   <= '1;
            pos    <= '0;
            tx_bit <= 1'b1;
        end else if (bit_en) begin
            if (at_boundary) begin
                if (load) begin
                    word   <= cw;
                    tx_bit <= cw[0];
                    pos    <= POS_W'(1);
                end else begin
                    tx_bit <= 1'b1;
                end
            end else begin
                tx_bit <= word[pos];
                pos    <= at_last ? '0 : pos + POS_W'(1);
            end
        end
    end

    // R7: output holds while the slot enable is low.
    a_r7_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit));
    // R2: every codeword begins with a 0.
    a_r2_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && load) |=> !tx_bit);
    // R2: the final bit of a codeword is a trailing 1.
    a_r2_trail_one: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && at_last) |=> tx_bit);
    // R3: a boundary slot with no load sends a 1.
    a_r3_idle_one: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && at_boundary && !load) |=> tx_bit);

endmodule

// File: rtl/feac_tx_seq.sv
// Repeat sequencer.
// Decides at each codeword boundary whether a codeword is loaded and
// which code it uses. It counts repeats and walks the mode's order:
// single is A x REPEAT; dual is A x REPEAT then B x REPEAT; continuous
// repeats A. A pending mode write is applied only at a boundary.
// Assumes at_boundary and at_last come from the shifter.
module feac_tx_seq
    import feac_tx_pkg::*;
#(
    parameter int REPEAT = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       at_boundary,
    input  logic       at_last,
    input  logic       pend,
    input  feac_mode_e mode,
    output logic       load,
    output logic       consume,
    output logic       use_b,
    output logic       done
);

    localparam int REP_W = (REPEAT > 1) ? $clog2(REPEAT) : 1;

    feac_phase_e phase;
    feac_phase_e phase_eff;
    feac_mode_e  run_mode;
    logic [REP_W-1:0] rep;
    logic word_done;
    logic last_rep;

    // Phase in force for this slot, with a pending mode write applied.
    always_comb begin
        phase_eff = phase;
        if (at_boundary && pend)
            phase_eff = (mode == MODE_IDLE) ? PH_OFF : PH_A;
    end

    assign consume   = bit_en & at_boundary & pend;
    assign load      = bit_en & at_boundary & (phase_eff != PH_OFF);
    assign use_b     = (phase_eff == PH_B);
    assign word_done = bit_en & at_last;
    assign last_rep  = (rep == REP_W'(REPEAT - 1));

    // Phase, repeat count, latched mode and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_OFF;
            rep      <= '0;
            run_mode <= MODE_IDLE;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (consume) begin
                phase    <= phase_eff;
                rep      <= '0;
                run_mode <= mode;
            end else if (word_done) begin
                if (run_mode == MODE_CONT) begin
                    rep <= '0;
                end else if (!last_rep) begin
                    rep <= rep + REP_W'(1);
                end else begin
                    rep <= '0;
                    if (phase == PH_A && run_mode == MODE_DUAL) begin
                        phase <= PH_B;
                    end else begin
                        phase <= PH_OFF;
                        done  <= 1'b1;
                    end
                end
            end
        end
    end

    // R5: the repeat count stays below the limit.
    a_r5_rep_range: assert property (@(posedge clk) disable iff (!rst_n)
        rep < REP_W'(REPEAT));
    // R10: done lasts one cycle.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: done coincides with the sequencer being off.
    a_r10_done_off: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (phase == PH_OFF));
    // R6: continuous mode never signals done.
    a_r6_cont_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode == MODE_CONT) |-> !done);

endmodule

// File: rtl/feac_tx.sv
// Far-end alarm codeword transmitter, top level.
// Connects the register file, the repeat sequencer and the codeword
// shifter. Selects code A or B for the next load.
// Assumes bit_en is a single-cycle pulse per serial bit slot.
module feac_tx
    import feac_tx_pkg::*;
#(
    parameter int CODE_W  = 6,
    parameter int REPEAT  = 10,
    parameter int TRAIL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_code_a,
    input  logic              wr_code_b,
    input  logic              wr_mode,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [1:0]        wr_mode_sel,
    input  logic              bit_en,
    output logic              tx_bit,
    output logic              seq_done
);

    logic [CODE_W-1:0] code_a;
    logic [CODE_W-1:0] code_b;
    logic [CODE_W-1:0] code_sel;
    feac_mode_e        mode;
    logic pend, consume, load, use_b, at_boundary, at_last;

    // Code that feeds the next codeword load.
    assign code_sel = use_b ? code_b : code_a;

    feac_tx_regs #(.CODE_W(CODE_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_code_a  (wr_code_a),
        .wr_code_b  (wr_code_b),
        .wr_mode    (wr_mode),
        .wr_code    (wr_code),
        .wr_mode_sel(wr_mode_sel),
        .consume    (consume),
        .code_a     (code_a),
        .code_b     (code_b),
        .mode       (mode),
        .pend       (pend)
    );

    feac_tx_seq #(.REPEAT(REPEAT)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .at_boundary(at_boundary),
        .at_last    (at_last),
        .pend       (pend),
        .mode       (mode),
        .load       (load),
        .consume    (consume),
        .use_b      (use_b),
        .done       (seq_done)
    );

    feac_tx_shift #(.CODE_W(CODE_W), .TRAIL_W(TRAIL_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .load       (load),
        .code       (code_sel),
        .tx_bit     (tx_bit),
        .at_boundary(at_boundary),
        .at_last    (at_last)
    );

endmodule

// File: tb/test_feac_tx.sv
`timescale 1ns/1ps
module test_feac_tx;

    localparam int REP    = 10;
    localparam int WORD_N = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_code_a = 1'b0, wr_code_b = 1'b0, wr_mode = 1'b0;
    logic [5:0] wr_code = '0;
    logic [1:0] wr_mode_sel = '0;
    logic       bit_en = 1'b0;
    logic       tx_bit, seq_done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    feac_tx i_feac_tx (
        .clk(clk), .rst_n(rst_n), .wr_code_a(wr_code_a), .wr_code_b(wr_code_b),
        .wr_mode(wr_mode), .wr_code(wr_code), .wr_mode_sel(wr_mode_sel),
        .bit_en(bit_en), .tx_bit(tx_bit), .seq_done(seq_done)
    );

    always #2 clk = ~clk;

    // Records one check and prints a line on mismatch.
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected bit i of the codeword for code c.
    function automatic logic exp_bit(input logic [5:0] c, input int i);
        if (i == 0 || i == 7) return 1'b0;
        if (i <= 6) return c[i-1];
        return 1'b1;
    endfunction

    // Runs one clock with the given enable; called and returns at a negedge.
    task automatic tick(input logic en);
        bit_en = en;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic write_mode(input logic [1:0] m);
        wr_mode = 1'b1; wr_mode_sel = m;
        @(negedge clk);
        wr_mode = 1'b0;
    endtask

    task automatic write_code(input bit sel_b, input logic [5:0] v);
        wr_code = v; wr_code_a = !sel_b; wr_code_b = sel_b;
        @(negedge clk);
        wr_code_a = 1'b0; wr_code_b = 1'b0;
    endtask

    // Checks codeword bits lo..hi of code c; fin marks the final word of a sequence.
    task automatic word_bits(input logic [5:0] c, input int lo, input int hi,
                             input bit fin, input string req);
        for (int i = lo; i <= hi; i++) begin
            tick(1'b1);
            chk(tx_bit == exp_bit(c, i), req, tx_bit, exp_bit(c, i));
            chk(seq_done == (fin && i == WORD_N - 1), "R10", seq_done, fin && i == WORD_N - 1);
        end
    endtask

    task automatic ones(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            tick(1'b1);
            chk(tx_bit == 1'b1, req, tx_bit, 1);
            chk(seq_done == 1'b0, "R10", seq_done, 0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [5:0] a_old, a_new;
        logic       prev;
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(tx_bit == 1'b1, "R1", tx_bit, 1);
        chk(seq_done == 1'b0, "R1", seq_done, 0);

        // R3: idle fill
        ones(20, "R3");
        write_mode(2'd0);
        ones(20, "R3");

        // R4 and R2: every code through single mode
        for (int c = 0; c < 64; c++) begin
            write_code(1'b0, 6'(c));
            write_mode(2'd1);
            for (int w = 0; w < REP; w++) word_bits(6'(c), 0, WORD_N - 1, w == REP - 1, "R2 R4");
            ones(3, "R4");
        end

        // R5: dual mode with every B code
        for (int b = 0; b < 64; b++) begin
            write_code(1'b0, 6'(63 - b) ^ 6'h15);
            write_code(1'b1, 6'(b));
            write_mode(2'd2);
            for (int w = 0; w < REP; w++) word_bits(6'(63 - b) ^ 6'h15, 0, WORD_N - 1, 1'b0, "R5");
            for (int w = 0; w < REP; w++) word_bits(6'(b), 0, WORD_N - 1, w == REP - 1, "R5");
            ones(3, "R5");
        end

        // R6: continuous mode well past ten codewords
        a_old = 6'b101100;
        write_code(1'b0, a_old);
        write_mode(2'd3);
        for (int w = 0; w < 25; w++) word_bits(a_old, 0, WORD_N - 1, 1'b0, "R6");

        // R7: gaps in the enable hold output and position
        for (int i = 0; i < WORD_N; i++) begin
            tick(1'b1);
            chk(tx_bit == exp_bit(a_old, i), "R7", tx_bit, exp_bit(a_old, i));
            prev = tx_bit;
            tick(1'b0);
            tick(1'b0);
            chk(tx_bit == prev, "R7", tx_bit, prev);
            chk(seq_done == 1'b0, "R7", seq_done, 0);
        end

        // R9: a code write mid-word affects only the next word
        a_new = 6'b010011;
        word_bits(a_old, 0, 4, 1'b0, "R9");
        write_code(1'b0, a_new);
        word_bits(a_old, 5, WORD_N - 1, 1'b0, "R9");
        word_bits(a_new, 0, WORD_N - 1, 1'b0, "R9");

        // R8: switch to single mid-word; the word completes, then a fresh sequence
        word_bits(a_new, 0, 6, 1'b0, "R8");
        write_mode(2'd1);
        word_bits(a_new, 7, WORD_N - 1, 1'b0, "R8");
        for (int w = 0; w < REP; w++) word_bits(a_new, 0, WORD_N - 1, w == REP - 1, "R8");
        ones(4, "R8");

        // R8: continuous then idle mid-word
        write_mode(2'd3);
        word_bits(a_new, 0, WORD_N - 1, 1'b0, "R8");
        word_bits(a_new, 0, 3, 1'b0, "R8");
        write_mode(2'd0);
        word_bits(a_new, 4, WORD_N - 1, 1'b0, "R8");
        ones(40, "R8");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule